// File: doc/BRIEF.md
# Half-Bridge Dead-Time Input Conditioner

This block conditions the switching commands for one phase leg of a three-phase power bridge. It takes two active-low commands, one for the high-side switch and one for the low-side switch. It filters each command against short glitches and inverts it into an on-request. It then decides which gate enable, if any, may be driven. The two enables are never on together. Whenever one switch turns off, a programmable dead interval passes before either switch may turn on.

A global shutdown from the fault controller removes both enables in the same cycle, with no filtering and no dead time on the way. A per-phase high-side undervoltage flag removes the high-side enable in the same way. A bootstrap-charge enable follows the low-side enable. It is forced off while an external overvoltage flag reports the floating supply above its limit. All timing is counted in clock cycles: the filter length and the two dead-time lengths are parameters, and an input selects which dead time is used.

Top module: `hb_deadtime_cond`

## Requirements
- R1: A command input held low (active) for at least FILT_CYC cycles turns on its gate enable; with no dead time pending, the enable rises on the (FILT_CYC+1)-th rising clock edge after the input changes. A high input level requests off.
- R2: A command level that lasts fewer than FILT_CYC consecutive sampled cycles is ignored and does not change either gate enable.
- R3: `hi_gate` and `lo_gate` are never both 1.
- R4: After an enable turns off, both enables stay off for exactly D cycles before the other one turns on. D = DT_SHORT when `dt_long_sel` = 0 and D = DT_LONG when `dt_long_sel` = 1, taken at the edge where the enable turns off.
- R5: While both filtered commands request on, both enables are off. Once only one request remains, its enable turns on after the filter delay and any dead time still pending.
- R6: While `shutdown` = 1, both enables are 0 in the same cycle, regardless of filter or dead-time state.
- R7: After `shutdown` returns to 0, an enable may turn on no earlier than the D-th rising edge after the release, with D chosen as in R4.
- R8: While `hs_uv` = 1, `hi_gate` is 0 in the same cycle and `lo_gate` is unaffected. After release, the high side turns on again at the next edge if its request is still present and no dead time is pending.
- R9: `boot_en` is 1 exactly when `lo_gate` = 1 and `vb_ovp` = 0.
- R10: Reset drives all outputs to 0 and loads the dead-time counter with the long interval, so that after reset release the first enable rises no earlier than the DT_LONG-th rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dt_long_sel | input | 1 | 1 selects DT_LONG dead time, 0 selects DT_SHORT |
| shutdown | input | 1 | Global shutdown, active high, forces both enables off |
| hs_uv | input | 1 | High-side supply undervoltage flag, forces high enable off |
| vb_ovp | input | 1 | Floating supply overvoltage flag, blocks bootstrap charging |
| hi_cmd_n | input | 1 | High-side command, active low |
| lo_cmd_n | input | 1 | Low-side command, active low |
| hi_gate | output | 1 | High-side gate enable |
| lo_gate | output | 1 | Low-side gate enable |
| boot_en | output | 1 | Bootstrap-charge enable |

## Verification
The bench builds the block with FILT_CYC = 3, DT_SHORT = 3 and DT_LONG = 8. With these values a two-cycle glitch lands exactly one cycle short of acceptance. The two dead-time lengths also differ clearly, so swapping them or dropping a cycle shows at the ports. The long value being larger than the short one lets the reset preload be told apart from the selected interval on the very first turn-on. All intervals stay far below the bench's settling waits, so every scenario starts from a known idle state.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

   typedef enum logic [1:0] {
      HB_IDLE = 2'd0,
      HB_HI   = 2'd1,
      HB_LO   = 2'd2
   } hb_state_e;

   localparam int unsigned HB_CH_HI = 0;
   localparam int unsigned HB_CH_LO = 1;
   localparam int unsigned HB_NCH   = 2;

endpackage

// File: rtl/hb_cmd_filter.sv
module hb_cmd_filter #(
   parameter int unsigned FILT_CYC = 4,
   parameter logic        IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic level
);

   generate
      if (FILT_CYC <= 1) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level <= IDLE_LVL;
            else        level <= raw;
         end
      end else begin : g_cnt
         localparam int unsigned FW = $clog2(FILT_CYC);
         localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);
         logic [FW-1:0] run;

         // a new level is accepted once it has been seen FILT_CYC times in a row
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level <= IDLE_LVL;
               run   <= '0;
            end else if (raw == level) begin
               run <= '0;
            end else if (run == LAST) begin
               level <= raw;
               run   <= '0;
            end else begin
               run <= run + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hb_dt_sequencer.sv
module hb_dt_sequencer
   import hb_dt_pkg::*;
#(
   parameter int unsigned DT_SHORT = 7,
   parameter int unsigned DT_LONG  = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_hi,
   input  logic req_lo,
   input  logic hi_block,
   input  logic halt,
   input  logic dt_long_sel,
   output logic hi_on,
   output logic lo_on
);

   localparam int unsigned CNT_W = $clog2(DT_LONG + 1);
   localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(DT_SHORT - 1);
   localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(DT_LONG - 1);

   hb_state_e      state;
   logic [CNT_W-1:0] dt_cnt;
   logic [CNT_W-1:0] dt_load;
   logic           want_hi;
   logic           want_lo;

   always_comb begin
      dt_load = dt_long_sel ? LOAD_LONG : LOAD_SHORT;
      // a double request counts as no request for either side
      want_hi = req_hi & ~req_lo & ~hi_block;
      want_lo = req_lo & ~req_hi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= HB_IDLE;
         dt_cnt <= LOAD_LONG;
      end else if (halt) begin
         state  <= HB_IDLE;
         dt_cnt <= dt_load;
      end else begin
         case (state)
            HB_HI: begin
               if (!want_hi) begin
                  state  <= HB_IDLE;
                  dt_cnt <= dt_load;
               end
            end
            HB_LO: begin
               if (!want_lo) begin
                  state  <= HB_IDLE;
                  dt_cnt <= dt_load;
               end
            end
            default: begin
               if (dt_cnt != '0)  dt_cnt <= dt_cnt - 1'b1;
               else if (want_hi)  state  <= HB_HI;
               else if (want_lo)  state  <= HB_LO;
            end
         endcase
      end
   end

   assign hi_on = (state == HB_HI);
   assign lo_on = (state == HB_LO);

endmodule

// File: rtl/hb_deadtime_cond.sv
module hb_deadtime_cond
   import hb_dt_pkg::*;
#(
   parameter int unsigned FILT_CYC = 4,
   parameter int unsigned DT_SHORT = 7,
   parameter int unsigned DT_LONG  = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dt_long_sel,
   input  logic shutdown,
   input  logic hs_uv,
   input  logic vb_ovp,
   input  logic hi_cmd_n,
   input  logic lo_cmd_n,
   output logic hi_gate,
   output logic lo_gate,
   output logic boot_en
);

   generate
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("hb_deadtime_cond: FILT_CYC must be at least 1");
      end
      if (DT_SHORT < 1 || DT_SHORT > DT_LONG) begin : g_bad_dt
         $error("hb_deadtime_cond: need 1 <= DT_SHORT <= DT_LONG");
      end
   endgenerate

   logic [HB_NCH-1:0] cmd_raw;
   logic [HB_NCH-1:0] cmd_flt;
   logic              hi_on;
   logic              lo_on;

   assign cmd_raw[HB_CH_HI] = hi_cmd_n;
   assign cmd_raw[HB_CH_LO] = lo_cmd_n;

   for (genvar ch = 0; ch < HB_NCH; ch++) begin : g_ch
      hb_cmd_filter #(
         .FILT_CYC (FILT_CYC),
         .IDLE_LVL (1'b1)
      ) u_flt (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (cmd_raw[ch]),
         .level (cmd_flt[ch])
      );
   end

   hb_dt_sequencer #(
      .DT_SHORT (DT_SHORT),
      .DT_LONG  (DT_LONG)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_hi      (~cmd_flt[HB_CH_HI]),
      .req_lo      (~cmd_flt[HB_CH_LO]),
      .hi_block    (hs_uv),
      .halt        (shutdown),
      .dt_long_sel (dt_long_sel),
      .hi_on       (hi_on),
      .lo_on       (lo_on)
   );

   // protective gating sits after the registers so it acts within the cycle
   assign hi_gate = hi_on & ~shutdown & ~hs_uv;
   assign lo_gate = lo_on & ~shutdown;
   assign boot_en = lo_gate & ~vb_ovp;

endmodule

// File: rtl/hb_deadtime_cond_chk.sv
module hb_deadtime_cond_chk #(
   parameter int unsigned DT_SHORT = 7
) (
   input logic clk,
   input logic rst_n,
   input logic shutdown,
   input logic hs_uv,
   input logic vb_ovp,
   input logic hi_gate,
   input logic lo_gate,
   input logic boot_en
);

   localparam logic [15:0] MIN_GAP = 16'(DT_SHORT);

   logic [15:0] idle_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   idle_run <= '0;
      else if (hi_gate || lo_gate)  idle_run <= '0;
      else if (idle_run != 16'hFFFF) idle_run <= idle_run + 16'd1;
   end

   // R3
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_gate && lo_gate));

   // R4
   dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hi_gate) || $rose(lo_gate)) |-> (idle_run >= MIN_GAP));

   // R6
   shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> (!hi_gate && !lo_gate));

   // R7
   release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shutdown) |-> (!hi_gate && !lo_gate));

   // R8
   uv_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_uv |-> !hi_gate);

   // R9
   boot_ovp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vb_ovp |-> !boot_en);

   // R9
   boot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_en |-> lo_gate);

endmodule

bind hb_deadtime_cond hb_deadtime_cond_chk #(
   .DT_SHORT (DT_SHORT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .shutdown (shutdown),
   .hs_uv    (hs_uv),
   .vb_ovp   (vb_ovp),
   .hi_gate  (hi_gate),
   .lo_gate  (lo_gate),
   .boot_en  (boot_en)
);

// File: tb/test_hb_deadtime_cond.sv
module test_hb_deadtime_cond;

   localparam int CLK_PERIOD = 10;
   localparam int F   = 3;
   localparam int DTS = 3;
   localparam int DTL = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dt_long_sel = 1'b0;
   logic shutdown = 1'b0;
   logic hs_uv = 1'b0;
   logic vb_ovp = 1'b0;
   logic hi_cmd_n = 1'b1;
   logic lo_cmd_n = 1'b1;
   logic hi_gate, lo_gate, boot_en;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hb_deadtime_cond #(
      .FILT_CYC (F),
      .DT_SHORT (DTS),
      .DT_LONG  (DTL)
   ) i_hb_deadtime_cond (
      .clk         (clk),
      .rst_n       (rst_n),
      .dt_long_sel (dt_long_sel),
      .shutdown    (shutdown),
      .hs_uv       (hs_uv),
      .vb_ovp      (vb_ovp),
      .hi_cmd_n    (hi_cmd_n),
      .lo_cmd_n    (lo_cmd_n),
      .hi_gate     (hi_gate),
      .lo_gate     (lo_gate),
      .boot_en     (boot_en)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic settle();
      hi_cmd_n = 1'b1;
      lo_cmd_n = 1'b1;
      step(20);
   endtask

   // R10 and R1: reset state, then long preload delays the first turn-on
   task automatic t_reset();
      @(negedge clk);
      check("R10", "hi after reset", hi_gate, 1'b0);
      check("R10", "lo after reset", lo_gate, 1'b0);
      check("R10", "boot after reset", boot_en, 1'b0);
      rst_n = 1'b1;
      hi_cmd_n = 1'b0;
      step(DTL - 1);
      check("R10", "hi still held by preload", hi_gate, 1'b0);
      step(1);
      check("R10", "hi on after long preload", hi_gate, 1'b1);
      settle();
   endtask

   // R1 and R9: plain turn-on latency for each side
   task automatic t_single_on();
      hi_cmd_n = 1'b0;
      step(F);
      check("R1", "hi before filter done", hi_gate, 1'b0);
      step(1);
      check("R1", "hi on", hi_gate, 1'b1);
      check("R1", "lo stays off", lo_gate, 1'b0);
      check("R9", "boot off with high side", boot_en, 1'b0);
      settle();
      lo_cmd_n = 1'b0;
      step(F);
      check("R1", "lo before filter done", lo_gate, 1'b0);
      step(1);
      check("R1", "lo on", lo_gate, 1'b1);
      check("R9", "boot follows low side", boot_en, 1'b1);
      settle();
   endtask

   // R4: handover with the chosen dead time, either direction
   task automatic t_handover(input logic sel, input logic to_lo);
      int d;
      d = sel ? DTL : DTS;
      dt_long_sel = sel;
      hi_cmd_n = to_lo ? 1'b0 : 1'b1;
      lo_cmd_n = to_lo ? 1'b1 : 1'b0;
      step(20);
      hi_cmd_n = ~hi_cmd_n;
      lo_cmd_n = ~lo_cmd_n;
      step(F + 1);
      check("R4", "old side off", to_lo ? hi_gate : lo_gate, 1'b0);
      check("R4", "new side waits", to_lo ? lo_gate : hi_gate, 1'b0);
      step(d - 1);
      check("R4", "new side still in dead time", to_lo ? lo_gate : hi_gate, 1'b0);
      step(1);
      check("R4", "new side on after dead time", to_lo ? lo_gate : hi_gate, 1'b1);
      settle();
      dt_long_sel = 1'b0;
   endtask

   // R2: short pulses are dropped
   task automatic t_glitch();
      hi_cmd_n = 1'b0;
      step(10);
      hi_cmd_n = 1'b1;
      step(F - 1);
      hi_cmd_n = 1'b0;
      step(10);
      check("R2", "hi survives off glitch", hi_gate, 1'b1);
      lo_cmd_n = 1'b0;
      step(F - 1);
      lo_cmd_n = 1'b1;
      step(10);
      check("R2", "lo ignores on glitch", lo_gate, 1'b0);
      check("R2", "hi unaffected by lo glitch", hi_gate, 1'b1);
      settle();
   endtask

   // R5: both requested
   task automatic t_both();
      hi_cmd_n = 1'b0;
      step(10);
      lo_cmd_n = 1'b0;
      step(F + 1);
      check("R5", "hi off on double request", hi_gate, 1'b0);
      step(20);
      check("R5", "hi held off", hi_gate, 1'b0);
      check("R5", "lo held off", lo_gate, 1'b0);
      hi_cmd_n = 1'b1;
      step(F);
      check("R5", "lo waits for filter", lo_gate, 1'b0);
      step(1);
      check("R5", "lo on once alone", lo_gate, 1'b1);
      settle();
   endtask

   // R6 and R7: shutdown and release
   task automatic t_shutdown();
      dt_long_sel = 1'b0;
      hi_cmd_n = 1'b0;
      step(10);
      shutdown = 1'b1;
      #1;
      check("R6", "hi off same cycle", hi_gate, 1'b0);
      step(5);
      check("R6", "hi held off", hi_gate, 1'b0);
      check("R6", "lo held off", lo_gate, 1'b0);
      shutdown = 1'b0;
      step(DTS - 1);
      check("R7", "hi waits after release", hi_gate, 1'b0);
      step(1);
      check("R7", "hi on after dead time", hi_gate, 1'b1);
      settle();
   endtask

   // R8: high-side undervoltage
   task automatic t_uv();
      hi_cmd_n = 1'b0;
      step(10);
      hs_uv = 1'b1;
      #1;
      check("R8", "hi off same cycle", hi_gate, 1'b0);
      step(10);
      check("R8", "hi held off", hi_gate, 1'b0);
      hs_uv = 1'b0;
      #1;
      check("R8", "hi not instantly back", hi_gate, 1'b0);
      step(1);
      check("R8", "hi back after release", hi_gate, 1'b1);
      settle();
      lo_cmd_n = 1'b0;
      step(10);
      hs_uv = 1'b1;
      step(3);
      check("R8", "lo unaffected by uv", lo_gate, 1'b1);
      hs_uv = 1'b0;
      settle();
   endtask

   // R9: bootstrap overvoltage block
   task automatic t_boot();
      lo_cmd_n = 1'b0;
      step(10);
      vb_ovp = 1'b1;
      #1;
      check("R9", "boot blocked by ovp", boot_en, 1'b0);
      check("R9", "lo kept by ovp", lo_gate, 1'b1);
      vb_ovp = 1'b0;
      #1;
      check("R9", "boot back after ovp", boot_en, 1'b1);
      settle();
      check("R9", "boot off with low side", boot_en, 1'b0);
   endtask

   initial begin
      t_reset();
      t_single_on();
      t_handover(1'b0, 1'b1);
      t_handover(1'b1, 1'b1);
      t_handover(1'b1, 1'b0);
      t_glitch();
      t_both();
      t_shutdown();
      t_uv();
      t_boot();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule